// File: doc/BRIEF.md
# Multi-Context Configuration Cache Controller

This controller manages configuration storage for a reconfigurable array built from sixteen logic rows, where every row keeps four configuration contexts. One context is active and drives execution. A load command names a configuration code, a starting row, a row count and a target context. The controller then takes wide configuration words from a second-level store through a valid/ready handshake. It writes one row per accepted word into the chosen context, and the array keeps running from the active context the whole time.

A switch command makes another context active one clock later. A load may not target the active context, and such a load is refused with an error pulse. A switch that names the context currently being loaded is held back and takes effect when that load finishes. A load descriptor comes either from immediate fields or from one packed register word.

The controller has three states. IDLE accepts a load; the transition IDLE to STREAM happens on an accepted, legal load. STREAM writes one row per beat; the transition STREAM to FINISH happens on the beat that writes the last row. FINISH raises the done pulse; the transition FINISH to IDLE is unconditional.

Top module: `ctx_cfg_cache_ctrl`

## Requirements
- R1: After reset the active context is 0, `busy`, `done`, `load_err`, `cfg_ready` and every `row_we` bit are 0, and `load_ready` is 1.
- R2: With `load_use_reg` at 0 the descriptor comes from the immediate inputs. With it at 1 the descriptor comes from `load_reg_word`, with the code in bits [7:0], the start row in [11:8], the row count in [16:12] and the context in [18:17]. The accepted code appears on `cfg_code` while streaming.
- R3: A load whose context equals the active context writes no row, leaves `busy` low and raises `load_err` for exactly the cycle after the request.
- R4: A load with a row count of 0 is refused in the same way as in R3.
- R5: A legal load writes rows start, start+1, ... in ascending order, one per accepted word. The region stops at the last row: a count that reaches past row 15 is cut to 16 minus start. At most one `row_we` bit is high at a time.
- R6: `cfg_ready` is high only in STREAM. A row is written only in a cycle where `cfg_valid` and `cfg_ready` are both high, so a cycle without valid data writes nothing and keeps the row position.
- R7: `done` is high for exactly one cycle, the cycle after the last row write. After that `load_ready` is high again.
- R8: A switch to a context that is not being loaded changes `active_layer` on the next clock edge, even while a load into another context is streaming.
- R9: A switch to the context under load leaves `active_layer` unchanged during the load and takes effect in the `done` cycle.
- R10: During a row write, `wr_layer` is the load's context and `wr_data` equals `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load command present |
| load_ready | output | 1 | Controller can take a load (IDLE) |
| load_use_reg | input | 1 | 1: descriptor from register word, 0: from immediates |
| load_imm_code | input | 8 | Immediate configuration code |
| load_imm_start | input | 4 | Immediate start row |
| load_imm_count | input | 5 | Immediate row count |
| load_imm_layer | input | 2 | Immediate target context |
| load_reg_word | input | 32 | Packed register descriptor |
| load_err | output | 1 | Refused load, one-cycle pulse |
| sw_valid | input | 1 | Context switch command |
| sw_layer | input | 2 | Context to make active |
| active_layer | output | 2 | Context used for execution |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Controller takes a configuration word |
| cfg_data | input | 192 | Configuration word from the store |
| cfg_code | output | 8 | Code of the configuration being streamed |
| row_we | output | 16 | Per-row write enable |
| wr_layer | output | 2 | Context written by `row_we` |
| wr_data | output | 192 | Word written into the enabled row |
| busy | output | 1 | High in STREAM |
| done | output | 1 | Load finished, one-cycle pulse |

## Verification
The bench uses the default parameters: sixteen rows, four contexts, a 192-bit word and an 8-bit code. With sixteen rows, one load covers the whole array, and a start at row 14 with a count of 5 exercises clamping at the top row. With four contexts there is always a spare context, so a switch to an unrelated context can be made while a load is streaming. The same settings allow a held switch to the loading context to be checked against the done cycle.

// File: rtl/ctx_cfg_pkg.sv
package ctx_cfg_pkg;
    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_STREAM = 2'd1,
        WR_FINISH = 2'd2
    } wr_state_e;
endpackage

// File: rtl/ctx_desc_decode.sv
module ctx_desc_decode #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_CTX  = 4,
    parameter int CODE_W   = 8,
    parameter int REG_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        use_reg,
    input  logic [CODE_W-1:0]           imm_code,
    input  logic [$clog2(NUM_ROWS)-1:0] imm_start,
    input  logic [$clog2(NUM_ROWS+1)-1:0] imm_count,
    input  logic [$clog2(NUM_CTX)-1:0]  imm_layer,
    input  logic [REG_W-1:0]            reg_word,
    output logic [CODE_W-1:0]           d_code,
    output logic [$clog2(NUM_ROWS)-1:0] d_start,
    output logic [$clog2(NUM_ROWS+1)-1:0] d_count,
    output logic [$clog2(NUM_CTX)-1:0]  d_layer,
    output logic                        d_empty
);
    localparam int ROW_W     = $clog2(NUM_ROWS);
    localparam int CNT_W     = $clog2(NUM_ROWS + 1);
    localparam int LAY_W     = $clog2(NUM_CTX);
    localparam int START_LSB = CODE_W;
    localparam int CNT_LSB   = START_LSB + ROW_W;
    localparam int LAY_LSB   = CNT_LSB + CNT_W;

    logic [ROW_W-1:0] raw_start;
    logic [CNT_W-1:0] raw_count;
    logic [CNT_W-1:0] room;

    always_comb begin
        if (use_reg) begin
            d_code    = reg_word[0 +: CODE_W];
            raw_start = reg_word[START_LSB +: ROW_W];
            raw_count = reg_word[CNT_LSB +: CNT_W];
            d_layer   = reg_word[LAY_LSB +: LAY_W];
        end else begin
            d_code    = imm_code;
            raw_start = imm_start;
            raw_count = imm_count;
            d_layer   = imm_layer;
        end
        room    = CNT_W'(NUM_ROWS) - CNT_W'(raw_start);
        d_start = raw_start;
        d_count = (raw_count > room) ? room : raw_count;
        d_empty = (raw_count == '0);
    end

    // R5: the clamped region never reaches past the last row
    assert_clamp_in_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, CNT_W'(d_start)} + {1'b0, d_count}) <= (CNT_W+1)'(NUM_ROWS));
endmodule

// File: rtl/ctx_row_writer.sv
module ctx_row_writer
    import ctx_cfg_pkg::*;
#(
    parameter int NUM_ROWS = 16,
    parameter int NUM_CTX  = 4,
    parameter int CODE_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [$clog2(NUM_ROWS)-1:0]   go_start,
    input  logic [$clog2(NUM_ROWS+1)-1:0] go_count,
    input  logic [$clog2(NUM_CTX)-1:0]    go_layer,
    input  logic [CODE_W-1:0]             go_code,
    input  logic                          cfg_valid,
    output logic                          cfg_ready,
    output logic [NUM_ROWS-1:0]           row_we,
    output logic [$clog2(NUM_CTX)-1:0]    wr_layer,
    output logic [CODE_W-1:0]             cfg_code,
    output logic                          idle,
    output logic                          busy,
    output logic                          done,
    output logic                          last_beat
);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam int CNT_W = $clog2(NUM_ROWS + 1);
    localparam int LAY_W = $clog2(NUM_CTX);

    wr_state_e        state_q, state_d;
    logic [ROW_W-1:0] cur_row_q;
    logic [CNT_W-1:0] rem_q;
    logic [LAY_W-1:0] layer_q;
    logic [CODE_W-1:0] code_q;
    logic             beat;

    assign beat = (state_q == WR_STREAM) && cfg_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   if (go) state_d = WR_STREAM;
            WR_STREAM: if (beat && rem_q == CNT_W'(1)) state_d = WR_FINISH;
            WR_FINISH: state_d = WR_IDLE;
            default:   state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WR_IDLE;
            cur_row_q <= '0;
            rem_q     <= '0;
            layer_q   <= '0;
            code_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WR_IDLE && go) begin
                cur_row_q <= go_start;
                rem_q     <= go_count;
                layer_q   <= go_layer;
                code_q    <= go_code;
            end else if (beat) begin
                cur_row_q <= cur_row_q + ROW_W'(1);
                rem_q     <= rem_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        idle      = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        cfg_ready = 1'b0;
        unique case (state_q)
            WR_IDLE:   idle = 1'b1;
            WR_STREAM: begin
                busy      = 1'b1;
                cfg_ready = 1'b1;
            end
            WR_FINISH: done = 1'b1;
            default:   idle = 1'b0;
        endcase
        last_beat = beat && (rem_q == CNT_W'(1));
        wr_layer  = layer_q;
        cfg_code  = code_q;
    end

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row_we
        assign row_we[g] = beat && (cur_row_q == ROW_W'(g));
    end

    assert_row_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));
    assert_streaming_has_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q != '0));
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> done);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && idle));
endmodule

// File: rtl/ctx_layer_ctrl.sv
module ctx_layer_ctrl #(
    parameter int NUM_CTX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_valid,
    input  logic [$clog2(NUM_CTX)-1:0] sw_layer,
    input  logic                       busy,
    input  logic                       last_beat,
    input  logic [$clog2(NUM_CTX)-1:0] tgt_layer,
    input  logic                       load_go,
    input  logic [$clog2(NUM_CTX)-1:0] go_layer,
    output logic [$clog2(NUM_CTX)-1:0] active_layer
);
    localparam int LAY_W = $clog2(NUM_CTX);

    logic             pend_q;
    logic [LAY_W-1:0] pend_layer_q;
    logic [LAY_W-1:0] active_q;
    logic             clash;

    assign clash = (busy && !last_beat && sw_layer == tgt_layer) ||
                   (load_go && sw_layer == go_layer);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q     <= '0;
            pend_q       <= 1'b0;
            pend_layer_q <= '0;
        end else if (sw_valid && clash) begin
            pend_q       <= 1'b1;
            pend_layer_q <= sw_layer;
        end else if (sw_valid) begin
            active_q <= sw_layer;
            pend_q   <= 1'b0;
        end else if (pend_q && last_beat) begin
            active_q <= pend_layer_q;
            pend_q   <= 1'b0;
        end
    end

    assign active_layer = active_q;

    assert_no_write_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (active_q != tgt_layer));
    assert_pending_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy);
    assert_quiet_keeps_layer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_valid && !last_beat) |=> $stable(active_q));
endmodule

// File: rtl/ctx_cfg_cache_ctrl.sv
module ctx_cfg_cache_ctrl #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_CTX  = 4,
    parameter int CFG_W    = 192,
    parameter int CODE_W   = 8,
    parameter int REG_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_valid,
    output logic                          load_ready,
    input  logic                          load_use_reg,
    input  logic [CODE_W-1:0]             load_imm_code,
    input  logic [$clog2(NUM_ROWS)-1:0]   load_imm_start,
    input  logic [$clog2(NUM_ROWS+1)-1:0] load_imm_count,
    input  logic [$clog2(NUM_CTX)-1:0]    load_imm_layer,
    input  logic [REG_W-1:0]              load_reg_word,
    output logic                          load_err,
    input  logic                          sw_valid,
    input  logic [$clog2(NUM_CTX)-1:0]    sw_layer,
    output logic [$clog2(NUM_CTX)-1:0]    active_layer,
    input  logic                          cfg_valid,
    output logic                          cfg_ready,
    input  logic [CFG_W-1:0]              cfg_data,
    output logic [CODE_W-1:0]             cfg_code,
    output logic [NUM_ROWS-1:0]           row_we,
    output logic [$clog2(NUM_CTX)-1:0]    wr_layer,
    output logic [CFG_W-1:0]              wr_data,
    output logic                          busy,
    output logic                          done
);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam int CNT_W = $clog2(NUM_ROWS + 1);
    localparam int LAY_W = $clog2(NUM_CTX);

    logic [CODE_W-1:0] d_code;
    logic [ROW_W-1:0]  d_start;
    logic [CNT_W-1:0]  d_count;
    logic [LAY_W-1:0]  d_layer;
    logic              d_empty;
    logic              idle, last_beat, load_fire, load_ok, err_q;

    ctx_desc_decode #(.NUM_ROWS(NUM_ROWS), .NUM_CTX(NUM_CTX), .CODE_W(CODE_W), .REG_W(REG_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .use_reg(load_use_reg),
        .imm_code(load_imm_code), .imm_start(load_imm_start),
        .imm_count(load_imm_count), .imm_layer(load_imm_layer),
        .reg_word(load_reg_word), .d_code(d_code), .d_start(d_start),
        .d_count(d_count), .d_layer(d_layer), .d_empty(d_empty)
    );

    assign load_ready = idle;
    assign load_fire  = load_valid && idle;
    assign load_ok    = load_fire && !d_empty && (d_layer != active_layer);

    ctx_row_writer #(.NUM_ROWS(NUM_ROWS), .NUM_CTX(NUM_CTX), .CODE_W(CODE_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .go(load_ok), .go_start(d_start),
        .go_count(d_count), .go_layer(d_layer), .go_code(d_code),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .row_we(row_we),
        .wr_layer(wr_layer), .cfg_code(cfg_code), .idle(idle), .busy(busy),
        .done(done), .last_beat(last_beat)
    );

    ctx_layer_ctrl #(.NUM_CTX(NUM_CTX)) u_layers (
        .clk(clk), .rst_n(rst_n), .sw_valid(sw_valid), .sw_layer(sw_layer),
        .busy(busy), .last_beat(last_beat), .tgt_layer(wr_layer),
        .load_go(load_ok), .go_layer(d_layer), .active_layer(active_layer)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= load_fire && !load_ok;
    end

    assign load_err = err_q;
    assign wr_data  = cfg_data;

    assert_err_no_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> !busy);
    assert_write_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_we != '0) |-> (cfg_ready && cfg_valid));
endmodule

// File: tb/tb_ctx_cfg_cache_ctrl.sv
module tb_ctx_cfg_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int NC = 4;
    localparam int CW = 192;
    localparam int KW = 8;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0, load_use_reg = 1'b0;
    logic [KW-1:0] load_imm_code = '0;
    logic [3:0]    load_imm_start = '0;
    logic [4:0]    load_imm_count = '0;
    logic [1:0]    load_imm_layer = '0;
    logic [RW-1:0] load_reg_word = '0;
    logic          sw_valid = 1'b0;
    logic [1:0]    sw_layer = '0;
    logic          cfg_valid = 1'b0;
    logic [CW-1:0] cfg_data = '0;
    logic          load_ready, load_err, cfg_ready, busy, done;
    logic [1:0]    active_layer, wr_layer;
    logic [KW-1:0] cfg_code;
    logic [NR-1:0] row_we;
    logic [CW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    ctx_cfg_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
        .load_use_reg(load_use_reg), .load_imm_code(load_imm_code),
        .load_imm_start(load_imm_start), .load_imm_count(load_imm_count),
        .load_imm_layer(load_imm_layer), .load_reg_word(load_reg_word),
        .load_err(load_err), .sw_valid(sw_valid), .sw_layer(sw_layer),
        .active_layer(active_layer), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_data(cfg_data), .cfg_code(cfg_code), .row_we(row_we),
        .wr_layer(wr_layer), .wr_data(wr_data), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic issue_load(input bit use_reg, input logic [7:0] code, input int start,
                              input int count, input int layer, input logic [31:0] word);
        @(negedge clk);
        load_use_reg   = use_reg;
        load_imm_code  = code;
        load_imm_start = start[3:0];
        load_imm_count = count[4:0];
        load_imm_layer = layer[1:0];
        load_reg_word  = word;
        load_valid     = 1'b1;
        #1 chk(load_ready === 1'b1, "R7 ready before load", 64'(load_ready), 1);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic expect_reject(input string req);
        #1;
        chk(load_err === 1'b1, req, 64'(load_err), 1);
        chk(busy === 1'b0 && row_we === '0, req, 64'({busy, row_we}), 0);
        @(negedge clk);
        #1;
        chk(load_err === 1'b0, req, 64'(load_err), 0);
        chk(load_ready === 1'b1, req, 64'(load_ready), 1);
    endtask

    // Streams n words after an accepted load; optional stall before beat stall_at,
    // optional switch on beat sw_beat, expected active layer after it and at done.
    task automatic stream(input int first, input int n, input int layer, input logic [7:0] code,
                          input int stall_at, input int sw_beat, input int sw_to,
                          input int exp_after_sw, input int exp_at_done);
        logic [CW-1:0] word;
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                cfg_valid = 1'b0;
                #1 chk(row_we === '0 && cfg_ready === 1'b1, "R6 stall writes nothing",
                       64'(row_we), 0);
                @(negedge clk);
            end
            word = {6{32'hC0DE_0000 | 32'(i) | (32'(layer) << 8)}};
            cfg_valid = 1'b1;
            cfg_data  = word;
            if (i == sw_beat) begin
                sw_valid = 1'b1;
                sw_layer = sw_to[1:0];
            end
            #1;
            chk(row_we === NR'(1) << (first + i), "R5 row order", 64'(row_we), 64'(NR'(1) << (first + i)));
            chk(wr_layer === layer[1:0] && wr_data === word, "R10 write layer/data",
                64'(wr_layer), 64'(layer));
            chk(cfg_code === code, "R2 streamed code", 64'(cfg_code), 64'(code));
            chk(done === 1'b0, "R7 no early done", 64'(done), 0);
            @(negedge clk);
            sw_valid = 1'b0;
            if (i == sw_beat && i < n - 1) begin
                #1 chk(active_layer === exp_after_sw[1:0], "R8/R9 layer after switch in load",
                       64'(active_layer), 64'(exp_after_sw));
            end
        end
        cfg_valid = 1'b0;
        #1;
        chk(done === 1'b1 && busy === 1'b0, "R7 done pulse", 64'({done, busy}), 2);
        chk(active_layer === exp_at_done[1:0], "R9 layer at done", 64'(active_layer), 64'(exp_at_done));
        @(negedge clk);
        #1;
        chk(done === 1'b0 && load_ready === 1'b1, "R7 single done, ready again",
            64'({done, load_ready}), 1);
    endtask

    task automatic t_reset;
        #1;
        chk(active_layer === 2'd0, "R1 active", 64'(active_layer), 0);
        chk(busy === 0 && done === 0 && load_err === 0 && cfg_ready === 0, "R1 flags",
            64'({busy, done, load_err, cfg_ready}), 0);
        chk(row_we === '0, "R1 row_we", 64'(row_we), 0);
        chk(load_ready === 1'b1, "R1 ready", 64'(load_ready), 1);
    endtask

    task automatic t_imm_load;
        issue_load(0, 8'h21, 3, 4, 1, 32'h0);
        stream(3, 4, 1, 8'h21, 2, -1, 0, 0, 0);
    endtask

    task automatic t_reject_active;
        issue_load(0, 8'h33, 0, 2, 0, 32'h0);
        expect_reject("R3 load into active layer");
    endtask

    task automatic t_reject_empty;
        issue_load(0, 8'h44, 5, 0, 2, 32'h0);
        expect_reject("R4 zero row count");
    endtask

    task automatic t_switch_idle;
        @(negedge clk);
        sw_valid = 1'b1;
        sw_layer = 2'd1;
        @(negedge clk);
        sw_valid = 1'b0;
        #1 chk(active_layer === 2'd1, "R8 switch in idle", 64'(active_layer), 1);
    endtask

    task automatic t_full_load_free_switch;
        // active 1; full array into layer 2; switch to 3 on beat 3 takes effect at once
        issue_load(0, 8'h7E, 0, 16, 2, 32'h0);
        stream(0, 16, 2, 8'h7E, -1, 3, 3, 3, 3);
    endtask

    task automatic t_reg_clamp_held_switch;
        logic [31:0] w;
        // active 3; reg descriptor: code 5A, start 14, count 5, layer 1; clamp to rows 14..15
        w = (32'd1 << 17) | (32'd5 << 12) | (32'd14 << 8) | 32'h5A;
        issue_load(1, 8'h00, 0, 0, 0, w);
        stream(14, 2, 1, 8'h5A, -1, 0, 1, 3, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_imm_load();
        t_reject_active();
        t_reject_empty();
        t_switch_idle();
        t_full_load_free_switch();
        t_reg_clamp_held_switch();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule